// File: doc/BRIEF.md
# I/O translation unit register bank

This block is the software-visible register file of an I/O address-translation unit. A host reaches it through a simple word-addressed port that carries a select, a write enable, an address, write data and registered read data. It stores the settings that the translator needs and exports them on dedicated outputs: the translation enable, the page-table base and the start of the device-virtual address window.

Each named register keeps only its writable bits. Some registers also force certain bits to one, and one register only accumulates set bits. The three-bit window-size code in the control register is decoded into the lowest address of a window that always ends at 0xFFFFFFFF. That start address is held in a register beside the control register.

The block also owns the fault interrupt line. The translator raises the line with a one-cycle pulse. Host accesses to the fault registers lower it. The two flush registers only store what is written to them.

Top module: `iommu_regbank`

## Requirements
- R1: After reset the registers read as follows: control = VERSION in bits 31:24 and zero below, page-table base 0, both flush registers 0, fault status 0x00800000, fault address 0, arbiter enable 0x00000003, slot configs 0, arbitration enable 0x00000008, mask ID 0x23000000. After reset win_start is 0xFF000000 and irq is 0.
- R2: A write to control (word 0x000) keeps only data bits 0, 2, 3 and 4 (mask 0x1D). Bits 31:24 always read as VERSION. Bit 0 drives xlate_en.
- R3: The control write also loads win_start from code bits 4:2, one cycle later. The value is 0xFFFFFFFF shifted left by 24+code, so code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: The page-table base (word 0x001) keeps data & 0x07FFFC00, and pt_base shows the stored value.
- R5: The two flush registers (words 0x005 and 0x006) and the fault address register (word 0x401) store the full 32-bit word.
- R6: The arbiter enable register (word 0x402) stores (data & 0x801F000F) | 0x1.
- R7: The fault status register (word 0x400) stores (data & 0xFF0FFFFF) | 0x00800000.
- R8: Each of the NUM_SLOTS slot configuration registers (words 0x404 upward) stores data & 0x00010003. A write to one slot leaves the other slots unchanged.
- R9: The arbitration enable register (word 0x800) stores (data & 0x001F0000) | 0x8.
- R10: A write to mask ID (word 0xC06) ORs data bits 23:0 into the stored value. No bit is ever cleared except by reset.
- R11: irq goes to 1 on the edge after a fault_raise pulse. Any of three accesses lowers it on its own edge: a read of fault status, a write of fault status, or a write of fault address. If a raise and a lowering access fall in the same cycle, the raise wins.
- R12: Reads of any unlisted word return 0, and writes to an unlisted word change no register.
- R13: rdata is loaded on the edge of a read access and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_sel | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered |
| fault_raise | input | 1 | One-cycle pulse from the translator that raises the interrupt |
| irq | output | 1 | Fault interrupt |
| xlate_en | output | 1 | Translation enable (control bit 0) |
| pt_base | output | 32 | Page-table base register value |
| win_start | output | 32 | Lowest address of the translation window |

## Verification
A wrong write mask or a missing forced bit shows up on the first read of that register after the write, one cycle after the read request. A wrong window decode shows up on win_start one cycle after the control write. Decode aliasing between neighbouring words shows up as a changed value on a later read of a register that was not written, so the random phase reads back every register many times. An interrupt that is not lowered or not raised is visible on irq on the edge right after the access or the pulse.

// File: rtl/iommu_regbank_pkg.sv
// Package: register indices, word addresses, write masks, forced bits and
// reset values for the translation-unit register bank.
// Assumes word addressing, and that a slot index i lives at SLOT_WORD0 + i.
package iommu_regbank_pkg;

    localparam int IDX_CTRL   = 0;
    localparam int IDX_BASE   = 1;
    localparam int IDX_TFLUSH = 2;
    localparam int IDX_PFLUSH = 3;
    localparam int IDX_FSTAT  = 4;
    localparam int IDX_FADDR  = 5;
    localparam int IDX_AER    = 6;
    localparam int IDX_ARBEN  = 7;
    localparam int IDX_MASKID = 8;
    localparam int IDX_SLOT0  = 9;

    localparam int SLOT_WORD0 = 32'h404;

    // Word address of register idx.
    function automatic logic [31:0] word_addr(input int idx);
        case (idx)
            IDX_CTRL:   return 32'h000;
            IDX_BASE:   return 32'h001;
            IDX_TFLUSH: return 32'h005;
            IDX_PFLUSH: return 32'h006;
            IDX_FSTAT:  return 32'h400;
            IDX_FADDR:  return 32'h401;
            IDX_AER:    return 32'h402;
            IDX_ARBEN:  return 32'h800;
            IDX_MASKID: return 32'hC06;
            default:    return 32'(SLOT_WORD0 + idx - IDX_SLOT0);
        endcase
    endfunction

    // Bits that a write may change.
    function automatic logic [31:0] field_mask(input int idx);
        case (idx)
            IDX_CTRL:   return 32'h0000_001D;
            IDX_BASE:   return 32'h07FF_FC00;
            IDX_FSTAT:  return 32'hFF0F_FFFF;
            IDX_AER:    return 32'h801F_000F;
            IDX_ARBEN:  return 32'h001F_0000;
            IDX_MASKID: return 32'h00FF_FFFF;
            IDX_TFLUSH, IDX_PFLUSH, IDX_FADDR: return 32'hFFFF_FFFF;
            default:    return 32'h0001_0003;
        endcase
    endfunction

    // Bits that always read as one.
    function automatic logic [31:0] field_force(input int idx, input logic [7:0] ver);
        case (idx)
            IDX_CTRL:  return {ver, 24'h0};
            IDX_FSTAT: return 32'h0080_0000;
            IDX_AER:   return 32'h0000_0001;
            IDX_ARBEN: return 32'h0000_0008;
            default:   return 32'h0;
        endcase
    endfunction

    // Value loaded by reset.
    function automatic logic [31:0] field_reset(input int idx, input logic [7:0] ver);
        case (idx)
            IDX_CTRL:   return {ver, 24'h0};
            IDX_FSTAT:  return 32'h0080_0000;
            IDX_AER:    return 32'h0000_0003;
            IDX_ARBEN:  return 32'h0000_0008;
            IDX_MASKID: return 32'h2300_0000;
            default:    return 32'h0;
        endcase
    endfunction

    // Registers that only accumulate set bits.
    function automatic bit field_accum(input int idx);
        return idx == IDX_MASKID;
    endfunction

    // Lowest address of a window that ends at 0xFFFFFFFF.
    function automatic logic [31:0] window_start(input logic [2:0] code);
        return 32'hFFFF_FFFF << (24 + int'(code));
    endfunction

endpackage

// File: rtl/iommu_reg_decode.sv
// Address decode: turns an access into a one-hot hit vector over the
// register list. Assumes every listed word address fits in ADDR_W bits.
// An unlisted address gives an all-zero vector.
module iommu_reg_decode
    import iommu_regbank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NREG   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit
);
    // One comparator per register.
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        always_comb hit[i] = sel && (addr == ADDR_W'(word_addr(i)));
    end

    // R12: no two registers may share an address.
    assert_onehot_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/iommu_reg_cell.sv
// One register of the bank. It applies its write mask and forced-one bits,
// or accumulates set bits when ACCUM is set. Assumes wr lasts one cycle
// per access.
module iommu_reg_cell #(
    parameter logic [31:0] RESET_VAL = 32'h0,
    parameter logic [31:0] MASK      = 32'hFFFF_FFFF,
    parameter logic [31:0] FORCE     = 32'h0,
    parameter bit          ACCUM     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] q
);
    // Storage update: reset value, masked write or OR accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (wr) begin
            if (ACCUM)
                q <= q | (wdata & MASK);
            else
                q <= (wdata & MASK) | FORCE;
        end
    end

    // R7 / R9 / R6 / R2: forced bits read as one at all times.
    assert_forced_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q & FORCE) == FORCE));

    if (ACCUM) begin : g_acc_chk
        // R10: an accumulating register never loses a bit.
        assert_no_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ((q & $past(q)) == $past(q)));
    end
endmodule

// File: rtl/iommu_window.sv
// Window decode: turns the control range code into the registered window
// start address. Assumes the code is only taken when the control register
// is written.
module iommu_window
    import iommu_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [2:0]  code,
    output logic [31:0] start
);
    // Register the start address for the translator.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start <= window_start(3'd0);
        else if (load)
            start <= window_start(code);
    end

    // R3: the window is at least 16 MB and at most 2 GB.
    assert_window_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (start[31] && start[23:0] == 24'h0));
    // R3: the start only moves on a control write.
    assert_window_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(start));
endmodule

// File: rtl/iommu_irq_ctrl.sv
// Fault interrupt: set by a translator pulse, cleared by host accesses to
// the fault registers. A raise takes priority over a clear in the same cycle.
module iommu_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic lower,
    output logic irq
);
    // Interrupt state: raise has priority over lower.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (raise)
            irq <= 1'b1;
        else if (lower)
            irq <= 1'b0;
    end

    assert_raise_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> irq);
    assert_lower_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lower && !raise) |=> !irq);
endmodule

// File: rtl/iommu_regbank.sv
// Top: register bank of the I/O translation unit. It is reached through a
// word-addressed port with registered read data. It exports the enable,
// the page-table base, the window start and the fault interrupt.
// Assumes a single access per cycle and that fault_raise is a pulse.
module iommu_regbank
    import iommu_regbank_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter int         NUM_SLOTS = 4,
    parameter logic [7:0] VERSION   = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_sel,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              fault_raise,
    output logic              irq,
    output logic              xlate_en,
    output logic [31:0]       pt_base,
    output logic [31:0]       win_start
);
    localparam int NREG = IDX_SLOT0 + NUM_SLOTS;

    logic [NREG-1:0] hit;
    logic [31:0]     regs_q [NREG];
    logic [31:0]     rd_mux;
    logic            rd_acc;
    logic            irq_lower;

    iommu_reg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel(acc_sel), .addr(acc_addr), .hit(hit)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        iommu_reg_cell #(
            .RESET_VAL(field_reset(i, VERSION)),
            .MASK     (field_mask(i)),
            .FORCE    (field_force(i, VERSION)),
            .ACCUM    (field_accum(i))
        ) u_cell (
            .clk(clk), .rst_n(rst_n), .wr(hit[i] && acc_we),
            .wdata(acc_wdata), .q(regs_q[i])
        );
    end

    iommu_window u_win (
        .clk(clk), .rst_n(rst_n), .load(hit[IDX_CTRL] && acc_we),
        .code(acc_wdata[4:2]), .start(win_start)
    );

    // Lowering accesses: any access to fault status, a write to fault address.
    always_comb irq_lower = hit[IDX_FSTAT] || (hit[IDX_FADDR] && acc_we);

    iommu_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .raise(fault_raise), .lower(irq_lower), .irq(irq)
    );

    // Read mux: OR of the selected register; zero when nothing is hit.
    always_comb begin
        rd_mux = 32'h0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) rd_mux |= regs_q[i];
    end

    always_comb rd_acc = acc_sel && !acc_we;

    // Read data register: loaded only on reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_rdata <= 32'h0;
        else if (rd_acc)
            acc_rdata <= rd_mux;
    end

    // Exported settings for the translator.
    always_comb xlate_en = regs_q[IDX_CTRL][0];
    always_comb pt_base  = regs_q[IDX_BASE];

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(acc_rdata));
    assert_unlisted_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && hit == '0) |=> (acc_rdata == 32'h0));
    assert_ctrl_version_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (regs_q[IDX_CTRL][31:24] == VERSION));
endmodule

// File: tb/tb_iommu_regbank.sv
module tb_iommu_regbank;
    localparam int         ADDR_W  = 12;
    localparam int         NSLOT   = 4;
    localparam logic [7:0] VER     = 8'h04;
    localparam int         NR      = 9 + NSLOT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_sel = 1'b0, acc_we = 1'b0, fault_raise = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       acc_rdata, pt_base, win_start;
    logic              irq, xlate_en;

    int checks = 0, errors = 0;
    logic [31:0] model [NR];

    always #4 clk = ~clk;

    iommu_regbank #(.ADDR_W(ADDR_W), .NUM_SLOTS(NSLOT), .VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .fault_raise(fault_raise), .irq(irq), .xlate_en(xlate_en),
        .pt_base(pt_base), .win_start(win_start)
    );

    // Bench view of the register list, written from the requirements.
    function automatic logic [ADDR_W-1:0] b_addr(input int i);
        case (i)
            0: return 12'h000; 1: return 12'h001; 2: return 12'h005;
            3: return 12'h006; 4: return 12'h400; 5: return 12'h401;
            6: return 12'h402; 7: return 12'h800; 8: return 12'hC06;
            default: return 12'(12'h404 + i - 9);
        endcase
    endfunction

    function automatic logic [31:0] b_reset(input int i);
        case (i)
            0: return {VER, 24'h0}; 4: return 32'h0080_0000;
            6: return 32'h3; 7: return 32'h8; 8: return 32'h2300_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] b_next(input int i, input logic [31:0] old, input logic [31:0] d);
        case (i)
            0: return (d & 32'h1D) | {VER, 24'h0};
            1: return d & 32'h07FF_FC00;
            2, 3, 5: return d;
            4: return (d & 32'hFF0F_FFFF) | 32'h0080_0000;
            6: return (d & 32'h801F_000F) | 32'h1;
            7: return (d & 32'h001F_0000) | 32'h8;
            8: return old | (d & 32'h00FF_FFFF);
            default: return d & 32'h0001_0003;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_sel = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_sel = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_sel = 1'b1; acc_we = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_sel = 1'b0;
        d = acc_rdata;
    endtask

    task automatic pulse_raise();
        @(negedge clk);
        fault_raise = 1'b1;
        @(negedge clk);
        fault_raise = 1'b0;
    endtask

    task automatic mwr(input int i, input logic [31:0] d);
        wr(b_addr(i), d);
        model[i] = b_next(i, model[i], d);
    endtask

    task automatic chk_reg(input string req, input int i);
        logic [31:0] v;
        rd(b_addr(i), v);
        check(req, v, model[i]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v, hold;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) model[i] = b_reset(i);

        // R1 reset values
        check("R1 win_start", win_start, 32'hFF00_0000);
        check("R1 irq", {31'h0, irq}, 32'h0);
        for (int i = 0; i < NR; i++) chk_reg("R1", i);

        // R2 control mask, version and enable
        mwr(0, 32'hFFFF_FFFF);
        check("R2 xlate_en", {31'h0, xlate_en}, 32'h1);
        chk_reg("R2", 0);
        // R3 window decode for every code
        for (int c = 0; c < 8; c++) begin
            mwr(0, 32'(c << 2));
            check("R3 win_start", win_start, 32'hFFFF_FFFF << (24 + c));
            check("R2 xlate_en off", {31'h0, xlate_en}, 32'h0);
        end
        // R4 base register and output
        mwr(1, 32'hFFFF_FFFF);
        check("R4 pt_base", pt_base, 32'h07FF_FC00);
        chk_reg("R4", 1);
        // R5 full-word registers
        mwr(2, 32'hA5A5_5A5A); chk_reg("R5 tflush", 2);
        mwr(3, 32'h1234_5678); chk_reg("R5 pflush", 3);
        mwr(5, 32'hDEAD_BEEF); chk_reg("R5 faddr", 5);
        // R6 R7 R9 forced bits with all-zero data
        mwr(6, 32'h0); chk_reg("R6", 6);
        mwr(4, 32'h0); chk_reg("R7", 4);
        mwr(7, 32'h0); chk_reg("R9", 7);
        // R8 slot independence
        mwr(9, 32'hFFFF_FFFF);
        for (int i = 9; i < NR; i++) chk_reg("R8", i);
        // R10 accumulation
        mwr(8, 32'h0000_0005); mwr(8, 32'hFF00_0002);
        chk_reg("R10", 8);
        check("R10 value", model[8], 32'h2300_0007);

        // R12 unlisted addresses
        wr(12'h002, 32'hFFFF_FFFF); wr(12'h403, 32'hFFFF_FFFF); wr(12'hFFF, 32'hFFFF_FFFF);
        rd(12'h002, v); check("R12 read zero", v, 32'h0);
        rd(12'h403, v); check("R12 read zero", v, 32'h0);
        for (int i = 0; i < NR; i++) chk_reg("R12 untouched", i);

        // R13 rdata holds between reads
        rd(b_addr(5), hold);
        wr(b_addr(2), 32'h0BAD_F00D); model[2] = 32'h0BAD_F00D;
        repeat (3) @(negedge clk);
        check("R13 hold", acc_rdata, hold);

        // R11 interrupt raise and lowering accesses
        pulse_raise(); check("R11 raise", {31'h0, irq}, 32'h1);
        chk_reg("R11 ctrl read keeps", 0);
        check("R11 ctrl read no lower", {31'h0, irq}, 32'h1);
        chk_reg("R11 fstat read", 4);
        check("R11 read lowers", {31'h0, irq}, 32'h0);
        pulse_raise(); rd(b_addr(5), v);
        check("R11 faddr read keeps", {31'h0, irq}, 32'h1);
        mwr(5, 32'h0000_1000);
        check("R11 faddr write lowers", {31'h0, irq}, 32'h0);
        pulse_raise(); mwr(4, 32'hFFFF_FFFF);
        check("R11 fstat write lowers", {31'h0, irq}, 32'h0);
        @(negedge clk);
        acc_sel = 1'b1; acc_we = 1'b0; acc_addr = b_addr(4); fault_raise = 1'b1;
        @(negedge clk);
        acc_sel = 1'b0; fault_raise = 1'b0;
        check("R11 raise wins", {31'h0, irq}, 32'h1);

        // Random mix of writes and reads
        for (int n = 0; n < 400; n++) begin
            int i, j;
            logic [31:0] d;
            i = int'($urandom_range(NR - 1, 0));
            j = int'($urandom_range(NR - 1, 0));
            d = $urandom();
            mwr(i, d);
            if (i == 0) check("R3 random win", win_start, 32'hFFFF_FFFF << (24 + int'(d[4:2])));
            chk_reg("R2-R10 random", j);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule